// File: doc/BRIEF.md
# Buck Channel Start-Up Sequencer

This block sequences the start-up of one buck channel inside a dual regulator. Comparators on the analog supply report three digital flags: the supply is above the power-on-reset level (about 3 V), above the upper lockout level (about 4.2 V), and above the lower lockout level (about 4.1 V). The block also takes a channel enable and a slow timebase tick. From these inputs it sets the mode of the gate driver, a stepped current-limit scale, a soft-start-done flag, a flag that arms undervoltage fault detection, and a one-cycle pulse that clears the channel's fault latch.

The supply first clears the power-on-reset level. Until the supply then reaches the upper lockout level, the low-side switch is held on and no switching happens. Once the supply is above that level and the channel is enabled, switching starts and the current limit climbs in quarter steps. One step lasts `STEP_TICKS` ticks. Undervoltage detection stays blanked for `BLANK_TICKS` ticks after switching begins. A later fall below the lower lockout level tristates both drivers, and the channel stays off until the upper level is crossed again. Removing the enable idles the channel with its drivers tristated.

Top module: `softstart_seq`

## Requirements
- R1: A rise of `por_ok` produces exactly one `fault_clr` pulse of one clock cycle. The next ramp always starts again from the first quarter step.
- R2: `drv_mode` uses these codes: 2'b00 means both drivers tristated, 2'b01 means low-side on, 2'b10 means normal switching. With `por_ok` low the code is 2'b00. With `por_ok` high and the upper lockout level never yet reached, the code is 2'b01 whatever `enable` is.
- R3: Once `uvlo_hi` has been seen, operation continues while only `uvlo_hi` is low and `uvlo_lo` stays high. When `uvlo_lo` falls, `drv_mode` becomes 2'b00. The channel recovers only after `uvlo_hi` rises again.
- R4: `ilim_q` counts quarters of the full current limit: 0 means off, 1 to 4 mean 25% to 100%. When switching starts, the value is 1. It rises by one after each `STEP_TICKS` counted ticks and never exceeds 4.
- R5: `uv_arm` stays low until `BLANK_TICKS` ticks have been counted since switching began. It is high only while switching.
- R6: `ss_done` rises only after code 4 has been held for `STEP_TICKS` ticks, which is `4*STEP_TICKS` ticks after the start. It is high only while `ilim_q` is 4 and the channel is switching.
- R7: When `enable` goes low, the block returns to `drv_mode` 2'b00 with `ilim_q` 0 and `ss_done` 0. The next enable restarts the ramp at code 1.
- R8: Ticks that arrive while the channel is not switching have no effect on later step timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Supply above power-on-reset level |
| uvlo_hi | input | 1 | Supply above upper lockout level |
| uvlo_lo | input | 1 | Supply above lower lockout level |
| enable | input | 1 | Channel enable |
| tick | input | 1 | Timebase tick, one cycle wide |
| drv_mode | output | 2 | Gate driver mode (R2 codes) |
| ilim_q | output | $clog2(NUM_STEPS+1) | Current-limit scale in quarters |
| ss_done | output | 1 | Soft-start complete |
| uv_arm | output | 1 | Undervoltage detection armed |
| fault_clr | output | 1 | One-cycle fault latch clear |

## Verification
The hardest situations to reach are the hysteresis band and the point where the blanking window ends after the ramp has already finished. The first is the case where `uvlo_hi` has dropped but `uvlo_lo` is still high. The second happens because the blank window is longer than the ramp, so `uv_arm` rises while the channel is in the run state. The bench runs with a short step and blank window, which lets ticks walk the ramp past `ss_done` and then into arming. Seeded random actions drop the two lockout flags separately, toggle the enable and power-on flags, and insert bursts of ticks. Ticks sent while idle check that they leave no trace.

// File: rtl/softstart_pkg.sv
// Shared types for the start-up sequencer.
// Assumes: drive codes are decoded by the gate-driver block next to this one.
package softstart_pkg;
    typedef enum logic [2:0] {
        ST_RESET,   // supply below power-on-reset level
        ST_UVLO,    // waiting for upper lockout level, low side held on
        ST_IDLE,    // supply fine, channel disabled
        ST_RAMP,    // switching, current limit stepping up
        ST_RUN,     // switching at full current limit
        ST_SHUT     // fell below lower lockout level, drivers off
    } ss_state_e;

    localparam logic [1:0] DRV_OFF    = 2'b00;
    localparam logic [1:0] DRV_LS_ON  = 2'b01;
    localparam logic [1:0] DRV_SWITCH = 2'b10;
endpackage

// File: rtl/ss_tick_timer.sv
// Tick counter with two variants chosen by SATURATE.
// Wrap variant: pulses hit on the tick that completes LIMIT ticks, then restarts.
// Saturate variant: hit is a level, high once LIMIT ticks are counted.
// Assumes: clear has priority over advance; LIMIT >= 1.
module ss_tick_timer #(
    parameter int unsigned LIMIT    = 4,
    parameter bit          SATURATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    generate
        if (SATURATE) begin : g_sat
            localparam logic [CW-1:0] TOP = CW'(LIMIT);
            // Count up to LIMIT and hold there.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    cnt_q <= '0;
                else if (advance && cnt_q != TOP)
                    cnt_q <= cnt_q + 1'b1;
            end
            assign hit = (cnt_q == TOP);
        end else begin : g_wrap
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
            // Count modulo LIMIT.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    cnt_q <= '0;
                else if (advance)
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            assign hit = advance && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ss_supply_track.sv
// Registers the supply comparator flags and keeps the lockout hysteresis.
// supply_ok is set by the upper flag and cleared by the lower flag or by
// loss of power-on reset; por_rise pulses one cycle after por_ok rises.
// Assumes: flags are already synchronous to clk.
module ss_supply_track (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok,
    input  logic above_hi,
    input  logic above_lo,
    output logic por_q,
    output logic supply_ok,
    output logic por_rise
);
    // Sample power-on flag and detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q    <= 1'b0;
            por_rise <= 1'b0;
        end else begin
            por_q    <= por_ok;
            por_rise <= por_ok & ~por_q;
        end
    end

    // Hysteresis latch between the two lockout levels.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_ok || !above_lo)
            supply_ok <= 1'b0;
        else if (above_hi)
            supply_ok <= 1'b1;
    end
endmodule

// File: rtl/softstart_seq.sv
// Start-up sequencer for one buck channel: power-on reset, lockout
// band with driver control, quarter-step current-limit ramp, and
// undervoltage blanking window.
// Assumes: tick is a single-cycle strobe from a shared timebase.
module softstart_seq #(
    parameter int unsigned NUM_STEPS   = 4,
    parameter int unsigned STEP_TICKS  = 400,
    parameter int unsigned BLANK_TICKS = 2000,
    localparam int unsigned STEP_W     = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              uvlo_hi,
    input  logic              uvlo_lo,
    input  logic              enable,
    input  logic              tick,
    output logic [1:0]        drv_mode,
    output logic [STEP_W-1:0] ilim_q,
    output logic              ss_done,
    output logic              uv_arm,
    output logic              fault_clr
);
    import softstart_pkg::*;

    localparam logic [STEP_W-1:0] STEP_FULL = STEP_W'(NUM_STEPS);

    ss_state_e         state_q, state_d;
    logic              por_q, supply_ok, por_rise;
    logic              step_wrap, blank_done;
    logic [STEP_W-1:0] step_q;
    logic              in_ramp_d, live_q, live_d;

    ss_supply_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_ok   (por_ok),
        .above_hi (uvlo_hi),
        .above_lo (uvlo_lo),
        .por_q    (por_q),
        .supply_ok(supply_ok),
        .por_rise (por_rise)
    );

    assign in_ramp_d = (state_d == ST_RAMP);
    assign live_q    = (state_q == ST_RAMP) || (state_q == ST_RUN);
    assign live_d    = (state_d == ST_RAMP) || (state_d == ST_RUN);

    ss_tick_timer #(.LIMIT(STEP_TICKS), .SATURATE(1'b0)) u_step_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!in_ramp_d),
        .advance(tick && (state_q == ST_RAMP)),
        .hit    (step_wrap)
    );

    ss_tick_timer #(.LIMIT(BLANK_TICKS), .SATURATE(1'b1)) u_blank_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!live_d),
        .advance(tick && live_q),
        .hit    (blank_done)
    );

    // Next-state selection; loss of power-on reset overrides everything.
    always_comb begin
        state_d = state_q;
        if (!por_q) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = ST_UVLO;
                ST_UVLO, ST_SHUT: begin
                    if (supply_ok) state_d = enable ? ST_RAMP : ST_IDLE;
                end
                ST_IDLE: begin
                    if (!supply_ok)  state_d = ST_SHUT;
                    else if (enable) state_d = ST_RAMP;
                end
                ST_RAMP: begin
                    if (!supply_ok)                          state_d = ST_SHUT;
                    else if (!enable)                        state_d = ST_IDLE;
                    else if (step_wrap && step_q == STEP_FULL) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!supply_ok)   state_d = ST_SHUT;
                    else if (!enable) state_d = ST_IDLE;
                end
                default: state_d = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Current-limit step: starts at one quarter, climbs on each step wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else if (in_ramp_d && state_q != ST_RAMP)
            step_q <= STEP_W'(1);
        else if (state_d == ST_RUN)
            step_q <= STEP_FULL;
        else if (in_ramp_d && step_wrap && step_q != STEP_FULL)
            step_q <= step_q + 1'b1;
        else if (!in_ramp_d)
            step_q <= '0;
    end

    // Driver mode decode from the registered state.
    always_comb begin
        unique case (state_q)
            ST_UVLO:         drv_mode = DRV_LS_ON;
            ST_RAMP, ST_RUN: drv_mode = DRV_SWITCH;
            default:         drv_mode = DRV_OFF;
        endcase
    end

    assign ilim_q    = step_q;
    assign ss_done   = (state_q == ST_RUN);
    assign uv_arm    = blank_done && live_q;
    assign fault_clr = por_rise;
endmodule

// File: rtl/softstart_seq_chk.sv
// Property checker for the start-up sequencer, bound to every instance.
// Assumes: observes only the ports of the sequencer.
module softstart_seq_chk #(
    parameter int unsigned STEP_W    = 3,
    parameter int unsigned NUM_STEPS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_ok,
    input logic [1:0]        drv_mode,
    input logic [STEP_W-1:0] ilim_q,
    input logic              ss_done,
    input logic              uv_arm,
    input logic              fault_clr
);
    localparam logic [STEP_W-1:0] FULL = STEP_W'(NUM_STEPS);

    p_clear_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault_clr);

    p_no_switch_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(por_ok, 2) |-> drv_mode != 2'b10);

    p_scale_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_q <= FULL);

    p_ramp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mode == 2'b10 && $past(drv_mode) != 2'b10) |-> ilim_q == STEP_W'(1));

    p_scale_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_q != '0 && $past(ilim_q) != '0) |->
            (ilim_q == $past(ilim_q) || ilim_q == $past(ilim_q) + 1'b1));

    p_arm_only_switching_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_arm |-> drv_mode == 2'b10);

    p_done_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ilim_q == FULL && drv_mode == 2'b10));

    p_done_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done) |-> $past(ilim_q) == FULL);
endmodule

bind softstart_seq softstart_seq_chk #(.STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_ok   (por_ok),
    .drv_mode (drv_mode),
    .ilim_q   (ilim_q),
    .ss_done  (ss_done),
    .uv_arm   (uv_arm),
    .fault_clr(fault_clr)
);

// File: tb/test_softstart_seq.sv
`timescale 1ns/1ps
module test_softstart_seq;
    localparam int S = 3;
    localparam int B = 14;
    localparam int M_RESET = 0, M_UVLO = 1, M_IDLE = 2, M_RAMP = 3, M_RUN = 4, M_SHUT = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic por = 1'b0, hi = 1'b0, lo = 1'b0, en = 1'b0, tick = 1'b0;
    logic [1:0] drv_mode;
    logic [2:0] ilim_q;
    logic ss_done, uv_arm, fault_clr;

    int n_cmp = 0, n_bad = 0;
    int mst = M_RESET, n = 0;
    bit mok = 0, finished = 0;

    always #10 clk = ~clk;

    softstart_seq #(.NUM_STEPS(4), .STEP_TICKS(S), .BLANK_TICKS(B)) i_softstart_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por), .uvlo_hi(hi), .uvlo_lo(lo),
        .enable(en), .tick(tick), .drv_mode(drv_mode), .ilim_q(ilim_q),
        .ss_done(ss_done), .uv_arm(uv_arm), .fault_clr(fault_clr)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_drv();
        if (mst == M_UVLO) return 1;
        if (mst == M_RAMP || mst == M_RUN) return 2;
        return 0;
    endfunction

    function automatic int exp_ilim();
        if (mst == M_RUN) return 4;
        if (mst == M_RAMP) return 1 + n / S;
        return 0;
    endfunction

    function automatic int exp_arm();
        return ((mst == M_RAMP || mst == M_RUN) && n >= B) ? 1 : 0;
    endfunction

    task automatic compare_all(string req);
        chk(req, "drv_mode", int'(drv_mode), exp_drv());
        chk(req, "ilim_q", int'(ilim_q), exp_ilim());
        chk(req, "ss_done", int'(ss_done), (mst == M_RUN) ? 1 : 0);
        chk(req, "uv_arm", int'(uv_arm), exp_arm());
    endtask

    // Reference model built from the requirements.
    task automatic model_update();
        if (!por) begin
            mst = M_RESET; mok = 0; n = 0;
        end else begin
            if (!lo) mok = 0; else if (hi) mok = 1;
            if (mst == M_RESET) mst = M_UVLO;
            if ((mst == M_UVLO || mst == M_SHUT) && mok) begin
                mst = en ? M_RAMP : M_IDLE; n = 0;
            end else if ((mst == M_IDLE || mst == M_RAMP || mst == M_RUN) && !mok) begin
                mst = M_SHUT;
            end else if (mst == M_IDLE && en) begin
                mst = M_RAMP; n = 0;
            end else if ((mst == M_RAMP || mst == M_RUN) && !en) begin
                mst = M_IDLE;
            end
        end
    endtask

    task automatic set_in(bit p, bit h, bit l, bit e, string req);
        int fc = 0;
        bit rising;
        rising = p && !por;
        @(negedge clk);
        por = p; hi = h; lo = l; en = e;
        model_update();
        repeat (4) begin
            @(negedge clk);
            if (fault_clr) fc++;
        end
        chk("R1", "fault_clr pulses", fc, rising ? 1 : 0);
        compare_all(req);
    endtask

    task automatic do_tick(string req);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (mst == M_RAMP || mst == M_RUN) begin
            n++;
            if (mst == M_RAMP && n == 4 * S) mst = M_RUN;
        end
        repeat (2) @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        void'($urandom(32'd1486));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R2 reset");
        // R2: above power-on level, lockout band, enable ignored
        set_in(1, 0, 0, 1, "R2");
        set_in(1, 0, 1, 1, "R2");
        // R4: leaving lockout starts the ramp at one quarter
        set_in(1, 1, 1, 1, "R4");
        // R4 R5 R6: walk the ramp through done and into arming
        for (int i = 0; i < 16; i++) do_tick(i < 12 ? "R4" : (i < 13 ? "R6" : "R5"));
        // R3: hysteresis band keeps switching, lower flag stops it
        set_in(1, 0, 1, 1, "R3");
        set_in(1, 0, 0, 1, "R3");
        set_in(1, 0, 1, 1, "R3");
        set_in(1, 1, 1, 1, "R3");
        do_tick("R4");
        // R7: disable idles and restart begins at one quarter
        set_in(1, 1, 1, 0, "R7");
        // R8: ticks while idle leave no trace
        for (int i = 0; i < 5; i++) do_tick("R8");
        set_in(1, 1, 1, 1, "R7");
        for (int i = 0; i < 3; i++) do_tick("R8");
        // R1: power-on reset during ramp, then restart
        set_in(0, 1, 1, 1, "R1");
        set_in(1, 1, 1, 1, "R1");
        // Seeded random actions
        for (int it = 0; it < 120; it++) begin
            int r = $urandom % 10;
            if (r < 5) begin
                int k = 1 + $urandom % 5;
                for (int j = 0; j < k; j++) do_tick("R4");
            end else if (r == 5) set_in(por, hi, lo, !en, "R7");
            else if (r == 6)     set_in(por, 0, lo, en, "R3");
            else if (r == 7)     set_in(por, 0, 0, en, "R3");
            else if (r == 8)     set_in(por, 1, 1, en, "R3");
            else                 set_in(!por, hi, lo, en, "R1");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule